// File: doc/BRIEF.md
# Selectable exact-rate tick generator

This block turns a fast free-running system clock into a single-cycle enable strobe at one of two exact low rates. With a 100 MHz clock the defaults give one strobe per second or ten strobes per second, picked at run time by a one-bit rate input. Downstream logic keeps running on the system clock and advances only in the cycles where the strobe is high, for example the seconds digit of a stopwatch.

Inside sits a single modulo counter. The counter counts up from zero, and a full-width equality compare detects the last count of the active period. That compare result is the strobe, and it also clears the counter on the following edge. Both period lengths are parameters, so a simulation can shrink them to a few cycles. A change of the rate input restarts the count from zero, so a count left over from the longer period can never run past the shorter terminal value.

Top module: `rate_tick_gen`

## Requirements
- R1: With `rate_sel_i` = 0 (slow rate) held steady, `tick_o` is high exactly once in every `SLOW_CYCLES` consecutive cycles, in the cycle where the count reaches `SLOW_CYCLES`-1.
- R2: With `rate_sel_i` = 1 (fast rate) held steady, `tick_o` is high exactly once in every `FAST_CYCLES` consecutive cycles.
- R3: `tick_o` is never high in two consecutive cycles, so each strobe lasts one clock cycle.
- R4: In a cycle where `rate_sel_i` differs from its value in the previous cycle, `tick_o` is low and the count restarts. The first strobe at the new rate appears N cycles after that cycle, where N is the period of the new rate.
- R5: `rst_i` is synchronous and active-high. `tick_o` is low in every cycle where `rst_i` is high, even if the count is at its terminal value. After the last reset cycle, the first strobe appears N cycles later.
- R6: The rate present at reset is adopted without a restart when reset is released. A select that changes during reset causes no extra delay afterwards.
- R7: `SLOW_CYCLES` and `FAST_CYCLES` must each be at least 2. The counter width is derived from the larger of the two, which gives 27 bits at the default values of 100,000,000 and 10,000,000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Synchronous active-high reset |
| rate_sel_i | input | 1 | Rate choice: 0 slow, 1 fast |
| tick_o | output | 1 | Single-cycle strobe at the chosen rate |

## Verification
On every cycle, the assertions check three things: the strobe never lasts two cycles, the count returns to zero after a terminal hit or a rate change, and the count never goes above the larger terminal value. The exact spacing between strobes, the delay from a reset or a select change to the first strobe, and the masking of the strobe during reset show up only in the bench's cycle-by-cycle scenarios. Those scenarios use short periods of 5 and 3 cycles.

// File: rtl/tick_pkg.sv
package tick_pkg;

   typedef enum logic {
      RATE_SLOW = 1'b0,
      RATE_FAST = 1'b1
   } rate_e;

   function automatic int unsigned max_cycles(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

   function automatic int unsigned count_width(input int unsigned cycles);
      return (cycles <= 2) ? 1 : $clog2(cycles);
   endfunction

endpackage

// File: rtl/tick_rate_sel.sv
module tick_rate_sel
   import tick_pkg::*;
#(
   parameter int unsigned SLOW_CYCLES = 100_000_000,
   parameter int unsigned FAST_CYCLES = 10_000_000,
   parameter int unsigned CNT_W       = 27
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             rate_sel_i,
   output logic             restart_o,
   output logic [CNT_W-1:0] term_o
);

   localparam logic [CNT_W-1:0] SLOW_TERM = CNT_W'(SLOW_CYCLES - 1);
   localparam logic [CNT_W-1:0] FAST_TERM = CNT_W'(FAST_CYCLES - 1);

   generate
      if (SLOW_CYCLES == FAST_CYCLES) begin : g_single_rate
         // Both rates equal: nothing to track, no restart ever needed.
         assign restart_o = 1'b0;
         assign term_o    = SLOW_TERM;
      end else begin : g_dual_rate
         rate_e rate_q;
         rate_e rate_now;

         assign rate_now = rate_e'(rate_sel_i);

         // Reset adopts the incoming select so release causes no restart (R6).
         always_ff @(posedge clk_i) begin
            rate_q <= rate_now;
         end

         assign restart_o = !rst_i && (rate_now != rate_q);
         assign term_o    = (rate_q == RATE_FAST) ? FAST_TERM : SLOW_TERM;

         // R4: a selected rate is held for a cycle before it may be compared.
         assert_rate_follow_R4: assert property (@(posedge clk_i) disable iff (rst_i)
            restart_o |=> (rate_q == $past(rate_now)));
      end
   endgenerate

endmodule

// File: rtl/tick_mod_counter.sv
module tick_mod_counter #(
   parameter int unsigned CNT_W    = 27,
   parameter int unsigned MAX_TERM = 99_999_999
) (
   input  logic             clk_i,
   input  logic             rst_i,
   input  logic             restart_i,
   input  logic [CNT_W-1:0] term_i,
   output logic             hit_o
);

   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);
   localparam logic [CNT_W-1:0] CNT_TOP = CNT_W'(MAX_TERM);

   logic [CNT_W-1:0] count_q;
   logic             clear;

   // Whole-value equality: a terminal count that is not a power of two
   // cannot be spotted from a single bit.
   assign hit_o = (count_q == term_i);
   assign clear = rst_i || restart_i || hit_o;

   always_ff @(posedge clk_i) begin
      if (clear) begin
         count_q <= '0;
      end else begin
         count_q <= count_q + CNT_ONE;
      end
   end

   // R1 R2: reaching the terminal value wraps to zero on the next edge.
   assert_wrap_zero_R1: assert property (@(posedge clk_i) disable iff (rst_i)
      hit_o |=> (count_q == '0));

   // R4: a rate change restarts the count.
   assert_restart_zero_R4: assert property (@(posedge clk_i) disable iff (rst_i)
      restart_i |=> (count_q == '0));

   // R7: the count never goes above the larger terminal value.
   assert_no_overflow_R7: assert property (@(posedge clk_i) disable iff (rst_i)
      count_q <= CNT_TOP);

endmodule

// File: rtl/rate_tick_gen.sv
module rate_tick_gen
   import tick_pkg::*;
#(
   parameter int unsigned SLOW_CYCLES = 100_000_000,
   parameter int unsigned FAST_CYCLES = 10_000_000
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic rate_sel_i,
   output logic tick_o
);

   localparam int unsigned MAX_CYC = max_cycles(SLOW_CYCLES, FAST_CYCLES);
   localparam int unsigned CNT_W   = count_width(MAX_CYC);

   // R7: elaboration-time parameter checks.
   generate
      if (SLOW_CYCLES < 2) begin : g_bad_slow
         $error("rate_tick_gen: SLOW_CYCLES must be at least 2");
      end
      if (FAST_CYCLES < 2) begin : g_bad_fast
         $error("rate_tick_gen: FAST_CYCLES must be at least 2");
      end
   endgenerate

   logic             restart;
   logic             hit;
   logic [CNT_W-1:0] term;

   tick_rate_sel #(
      .SLOW_CYCLES (SLOW_CYCLES),
      .FAST_CYCLES (FAST_CYCLES),
      .CNT_W       (CNT_W)
   ) u_rate_sel (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .rate_sel_i (rate_sel_i),
      .restart_o  (restart),
      .term_o     (term)
   );

   tick_mod_counter #(
      .CNT_W    (CNT_W),
      .MAX_TERM (MAX_CYC - 1)
   ) u_counter (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .restart_i (restart),
      .term_i    (term),
      .hit_o     (hit)
   );

   // The comparator result is the strobe, masked in reset and restart cycles.
   assign tick_o = hit && !rst_i && !restart;

   // R3: every strobe lasts exactly one clock cycle.
   assert_single_cycle_R3: assert property (@(posedge clk_i) disable iff (rst_i)
      tick_o |=> !tick_o);

endmodule

// File: tb/tb_rate_tick_gen.sv
module tb_rate_tick_gen;

   localparam int CLK_PERIOD = 10;
   localparam int SLOW_N     = 5;
   localparam int FAST_N     = 3;
   localparam int NUM_VEC    = 49;

   // Each row: {rst, rate_sel, expected tick}, one row per clock cycle.
   localparam logic [2:0] VEC [0:NUM_VEC-1] = '{
      3'b100, 3'b100, 3'b000, 3'b000, 3'b000, 3'b000, 3'b001, 3'b000,
      3'b000, 3'b000, 3'b000, 3'b001, 3'b010, 3'b010, 3'b010, 3'b011,
      3'b010, 3'b010, 3'b011, 3'b010, 3'b000, 3'b000, 3'b000, 3'b000,
      3'b000, 3'b001, 3'b010, 3'b010, 3'b010, 3'b011, 3'b010, 3'b010,
      3'b000, 3'b000, 3'b000, 3'b000, 3'b000, 3'b001, 3'b100, 3'b000,
      3'b000, 3'b000, 3'b000, 3'b100, 3'b000, 3'b110, 3'b010, 3'b010,
      3'b011
   };

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sel = 1'b0;
   logic tick;
   int   n_vec  = 0;
   int   n_fail = 0;
   bit   done   = 1'b0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   rate_tick_gen #(
      .SLOW_CYCLES (SLOW_N),
      .FAST_CYCLES (FAST_N)
   ) dut (
      .clk_i      (clk),
      .rst_i      (rst),
      .rate_sel_i (sel),
      .tick_o     (tick)
   );

   task automatic step(input logic r, input logic s);
      @(negedge clk);
      rst = r;
      sel = s;
      #1;
   endtask

   task automatic check(input string req, input logic act, input logic exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: tick=%b expected %b", req, $time, act, exp);
      end
   endtask

   initial begin
      int ticks;
      logic prev;
      // Table walk: R1 R2 R4 R5 R6 (period, restart, reset masking).
      for (int i = 0; i < NUM_VEC; i++) begin
         step(VEC[i][2], VEC[i][1]);
         check($sformatf("R1/R2/R4/R5/R6 vector %0d", i), tick, VEC[i][0]);
      end

      // R5: reset held for several cycles keeps the strobe low.
      for (int i = 0; i < 8; i++) begin
         step(1'b1, 1'b0);
         check("R5 held reset", tick, 1'b0);
      end

      // R1: slow run of 25 cycles, first strobe in cycle index SLOW_N-1.
      ticks = 0;
      for (int i = 0; i < 25; i++) begin
         step(1'b0, 1'b0);
         if (tick) ticks++;
         if (i == SLOW_N - 1) check("R1 first slow tick", tick, 1'b1);
      end
      check("R1 slow tick count", ticks == 5, 1'b1);

      // R2 R3: fast run of 30 cycles after a restart, strobes never adjacent.
      step(1'b0, 1'b1);
      check("R4 restart cycle", tick, 1'b0);
      ticks = 0;
      prev  = 1'b0;
      for (int i = 0; i < 30; i++) begin
         step(1'b0, 1'b1);
         if (tick) ticks++;
         if (prev && tick) check("R3 adjacent ticks", tick, 1'b0);
         prev = tick;
      end
      check("R2 fast tick count", ticks == 10, 1'b1);
      check("R3 no adjacent ticks seen", ticks <= 15, 1'b1);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: run did not finish, actual hung expected done");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
         $finish;
      end
   end

endmodule